// File: doc/BRIEF.md
# Timestamped Sample Packet Framer

This block turns a continuous stream of 32-bit receive samples into self-describing data packets for a host link. Every packet starts with a fixed prefix of five 32-bit words: a header that gives the packet kind, a late flag, a rolling packet number and the total length, then a stream identifier, then a whole-seconds timestamp, then a 64-bit fractional-seconds timestamp sent as two words. The configured number of payload samples follows the prefix.

Both timestamp parts are taken from a free-running time bus in the clock cycle that the first sample of a packet is accepted. That sample is held inside the block while the prefix goes out, so the time in the prefix belongs to the first payload word. Software can arm a start time. If the first sample of a packet is taken after that time, the header marks the packet as late. The input and output are valid/ready streams, and the output carries start and end markers.

Top module: `sample_packet_framer`

## Requirements
- R1: After reset `outValid`, `outSop` and `outEop` are low, `inReady` is high, and the first packet carries packet number 0.
- R2: The header word holds the value 4'h1 in bits [31:28], the late flag in bit 27, zeros in bits [26:20], the packet number in bits [19:16], and in bits [15:0] the total packet length in words (payload samples plus 5).
- R3: Each packet goes out in this order: header, stream identifier, whole seconds, fraction bits [63:32], fraction bits [31:0], then the payload samples in arrival order. `outSop` is high on the header word only.
- R4: The seconds and fraction words equal the time bus value in the cycle where the first sample of the packet is accepted.
- R5: Once a packet's first sample is accepted, `inReady` stays low until the five prefix words and that first sample have all been delivered.
- R6: A packet carries `pktLen` samples, with a setting of 0 treated as 1. `outEop` is high on the last payload word only, and the block then returns to idle.
- R7: The late flag is 1 only when `startEn` is high and the captured 96-bit time {seconds, fraction} is strictly greater than {`startSec`, `startFrac`}. An equal time is not late.
- R8: The packet number goes up by one after every completed packet and wraps from 15 to 0.
- R9: While `outValid` is high and `outReady` is low, `outData` does not change.
- R10: The stream identifier and `pktLen` are sampled together with the first sample. Changing them later has no effect on the packet in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input sample valid |
| inReady | output | 1 | Block accepts an input sample |
| inData | input | 32 | Input sample |
| outValid | output | 1 | Output word valid |
| outReady | input | 1 | Downstream accepts an output word |
| outData | output | 32 | Output word |
| outSop | output | 1 | Marks the first word (header) of a packet |
| outEop | output | 1 | Marks the last payload word of a packet |
| timeSec | input | 32 | Time bus, whole seconds |
| timeFrac | input | 64 | Time bus, fractional seconds |
| streamId | input | 32 | Stream identifier to insert |
| pktLen | input | 16 | Payload samples per packet (0 means 1) |
| startEn | input | 1 | Enables the late check |
| startSec | input | 32 | Start time, whole seconds |
| startFrac | input | 64 | Start time, fractional seconds |

## Verification
The hardest case to reach is the boundary of the late check. The time bus moves every cycle, so the bench cannot normally make the captured time equal the start time. The bench therefore freezes its own time counter, copies the frozen value into the start time, and then sends packets with the start time equal to, just below, and (with the check disabled) below the captured time. A second hard case is a change to the stream identifier and length just after the first sample is taken. The bench watches for that acceptance and rewrites both settings on the next clock edge, while the prefix is still going out.

// File: rtl/framer_pkg.sv
package framer_pkg;

  localparam int WORD_W       = 32;
  localparam int PREFIX_WORDS = 5;
  localparam int HDR_LEN_W    = 16;
  localparam int CNT_W        = 4;
  localparam logic [3:0] PKT_KIND = 4'h1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_SID, ST_SEC, ST_FHI, ST_FLO, ST_FIRST, ST_BODY
  } frameState_t;

  typedef enum logic [2:0] {
    SEL_HDR, SEL_SID, SEL_SEC, SEL_FHI, SEL_FLO, SEL_HELD, SEL_LIVE
  } wordSel_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic     capture;   // first sample accepted this cycle
    logic     pktDone;   // last payload word handed over this cycle
    wordSel_t wordSel;   // which word drives the output
  } ctrlStrobe_t;

endpackage

// File: rtl/framer_late_cmp.sv
module framer_late_cmp #(
  parameter int SEC_W   = 32,
  parameter int FRAC_W  = 64,
  parameter bit ENABLE  = 1'b1
) (
  input  logic [SEC_W-1:0]  timeSec,
  input  logic [FRAC_W-1:0] timeFrac,
  input  logic [SEC_W-1:0]  startSec,
  input  logic [FRAC_W-1:0] startFrac,
  input  logic              startEn,
  output logic              isLate
);

  localparam int FULL_W = SEC_W + FRAC_W;

  generate
    if (ENABLE) begin : gen_cmp
      logic [FULL_W-1:0] nowTime;
      logic [FULL_W-1:0] armTime;
      always_comb begin
        nowTime = {timeSec, timeFrac};
        armTime = {startSec, startFrac};
        isLate  = startEn && (nowTime > armTime);
      end
    end else begin : gen_off
      assign isLate = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/framer_ctrl.sv
module framer_ctrl
  import framer_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             outReady,
  input  logic [LEN_W-1:0] pktLen,
  output logic             inReady,
  output logic             outValid,
  output logic             outSop,
  output logic             outEop,
  output logic [LEN_W-1:0] effLen,
  output ctrlStrobe_t      strobe
);

  frameState_t      stateQ, stateNext;
  logic [LEN_W-1:0] remainQ, remainNext;
  logic             lastOne;

  always_comb begin
    effLen = (pktLen == '0) ? LEN_W'(1) : pktLen;
  end

  assign lastOne = (remainQ == LEN_W'(1));

  always_comb begin
    inReady        = 1'b0;
    outValid       = 1'b0;
    outSop         = 1'b0;
    outEop         = 1'b0;
    strobe         = '0;
    strobe.wordSel = SEL_HDR;
    stateNext      = stateQ;
    remainNext     = remainQ;
    unique case (stateQ)
      ST_IDLE: begin
        inReady = 1'b1;
        if (inValid) begin
          strobe.capture = 1'b1;
          remainNext     = effLen;
          stateNext      = ST_HDR;
        end
      end
      ST_HDR: begin
        outValid       = 1'b1;
        outSop         = 1'b1;
        strobe.wordSel = SEL_HDR;
        if (outReady) stateNext = ST_SID;
      end
      ST_SID: begin
        outValid       = 1'b1;
        strobe.wordSel = SEL_SID;
        if (outReady) stateNext = ST_SEC;
      end
      ST_SEC: begin
        outValid       = 1'b1;
        strobe.wordSel = SEL_SEC;
        if (outReady) stateNext = ST_FHI;
      end
      ST_FHI: begin
        outValid       = 1'b1;
        strobe.wordSel = SEL_FHI;
        if (outReady) stateNext = ST_FLO;
      end
      ST_FLO: begin
        outValid       = 1'b1;
        strobe.wordSel = SEL_FLO;
        if (outReady) stateNext = ST_FIRST;
      end
      ST_FIRST: begin
        outValid       = 1'b1;
        outEop         = lastOne;
        strobe.wordSel = SEL_HELD;
        if (outReady) begin
          if (lastOne) begin
            strobe.pktDone = 1'b1;
            stateNext      = ST_IDLE;
          end else begin
            remainNext = remainQ - LEN_W'(1);
            stateNext  = ST_BODY;
          end
        end
      end
      ST_BODY: begin
        outValid       = inValid;
        inReady        = outReady;
        outEop         = lastOne;
        strobe.wordSel = SEL_LIVE;
        if (inValid && outReady) begin
          if (lastOne) begin
            strobe.pktDone = 1'b1;
            stateNext      = ST_IDLE;
          end else begin
            remainNext = remainQ - LEN_W'(1);
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      remainQ <= '0;
    end else begin
      stateQ  <= stateNext;
      remainQ <= remainNext;
    end
  end

  // R5: a taken first sample closes the input for the next cycle
  assert_first_blocks_input_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && inValid && inReady) |=> !inReady);

  // R6: after the end marker is handed over, nothing is offered next cycle
  assert_eop_then_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outEop) |=> !outValid);

  // R6: the remaining-sample count never runs dry inside a packet
  assert_remain_nonzero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ != ST_IDLE) |-> (remainQ != '0));

  // R3: the start marker appears once per packet
  assert_single_sop_R3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outSop) |=> !outSop);

endmodule

// File: rtl/framer_dp.sv
module framer_dp
  import framer_pkg::*;
#(
  parameter int LEN_W      = 16,
  parameter bit LATE_CHECK = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              outValid,
  input  logic              outReady,
  input  logic [WORD_W-1:0] inData,
  input  logic [31:0]       timeSec,
  input  logic [63:0]       timeFrac,
  input  logic [31:0]       streamId,
  input  logic [LEN_W-1:0]  effLen,
  input  logic              startEn,
  input  logic [31:0]       startSec,
  input  logic [63:0]       startFrac,
  output logic [WORD_W-1:0] outData
);

  logic [WORD_W-1:0]    heldSample;
  logic [31:0]          capSec;
  logic [63:0]          capFrac;
  logic [31:0]          capSid;
  logic [HDR_LEN_W-1:0] capWords;
  logic                 lateFlag;
  logic [CNT_W-1:0]     pktCount;
  logic                 lateNow;
  logic [HDR_LEN_W-1:0] totalWords;
  logic [WORD_W-1:0]    hdrWord;

  framer_late_cmp #(
    .SEC_W (32),
    .FRAC_W(64),
    .ENABLE(LATE_CHECK)
  ) lateCmp_i (
    .timeSec  (timeSec),
    .timeFrac (timeFrac),
    .startSec (startSec),
    .startFrac(startFrac),
    .startEn  (startEn),
    .isLate   (lateNow)
  );

  assign totalWords = HDR_LEN_W'(effLen) + HDR_LEN_W'(PREFIX_WORDS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldSample <= '0;
      capSec     <= '0;
      capFrac    <= '0;
      capSid     <= '0;
      capWords   <= '0;
      lateFlag   <= 1'b0;
    end else if (strobe.capture) begin
      heldSample <= inData;
      capSec     <= timeSec;
      capFrac    <= timeFrac;
      capSid     <= streamId;
      capWords   <= totalWords;
      lateFlag   <= lateNow;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pktCount <= '0;
    end else if (strobe.pktDone) begin
      pktCount <= pktCount + CNT_W'(1);
    end
  end

  assign hdrWord = {PKT_KIND, lateFlag, 7'b0, pktCount, capWords};

  always_comb begin
    unique case (strobe.wordSel)
      SEL_HDR:  outData = hdrWord;
      SEL_SID:  outData = capSid;
      SEL_SEC:  outData = capSec;
      SEL_FHI:  outData = capFrac[63:32];
      SEL_FLO:  outData = capFrac[31:0];
      SEL_HELD: outData = heldSample;
      SEL_LIVE: outData = inData;
      default:  outData = '0;
    endcase
  end

  // R9: a prefix or held word offered but not taken stays put
  assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && strobe.wordSel != SEL_LIVE) |=> $stable(outData));

  // R8: packet number advances by exactly one per finished packet
  assert_count_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pktDone |=> (pktCount == $past(pktCount) + CNT_W'(1)));

  // R7: no late mark without the check armed
  assert_late_needs_enable_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && !startEn) |=> !lateFlag);

endmodule

// File: rtl/sample_packet_framer.sv
module sample_packet_framer
  import framer_pkg::*;
#(
  parameter int LEN_W      = 16,
  parameter bit LATE_CHECK = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic [31:0]      inData,
  output logic             outValid,
  input  logic             outReady,
  output logic [31:0]      outData,
  output logic             outSop,
  output logic             outEop,
  input  logic [31:0]      timeSec,
  input  logic [63:0]      timeFrac,
  input  logic [31:0]      streamId,
  input  logic [LEN_W-1:0] pktLen,
  input  logic             startEn,
  input  logic [31:0]      startSec,
  input  logic [63:0]      startFrac
);

  ctrlStrobe_t      strobe;
  logic [LEN_W-1:0] effLen;

  framer_ctrl #(.LEN_W(LEN_W)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .outReady(outReady),
    .pktLen  (pktLen),
    .inReady (inReady),
    .outValid(outValid),
    .outSop  (outSop),
    .outEop  (outEop),
    .effLen  (effLen),
    .strobe  (strobe)
  );

  framer_dp #(.LEN_W(LEN_W), .LATE_CHECK(LATE_CHECK)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .outValid (outValid),
    .outReady (outReady),
    .inData   (inData),
    .timeSec  (timeSec),
    .timeFrac (timeFrac),
    .streamId (streamId),
    .effLen   (effLen),
    .startEn  (startEn),
    .startSec (startSec),
    .startFrac(startFrac),
    .outData  (outData)
  );

endmodule

// File: tb/sample_packet_framer_tb_top.sv
module sample_packet_framer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] DATA_BASE = 32'hA000_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [31:0] inData = '0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [31:0] outData;
  logic        outSop, outEop;
  logic [31:0] timeSec = 32'h0000_0100;
  logic [63:0] timeFrac = 64'hFFFF_FFFF_FFFF_FFF8;
  logic [31:0] streamId = 32'h5151_0001;
  logic [15:0] pktLen = 16'd4;
  logic        startEn = 1'b0;
  logic [31:0] startSec = '0;
  logic [63:0] startFrac = '0;

  int nChecks = 0;
  int nFail = 0;
  int cycles = 0;

  // bench-side traffic state
  bit          timeRun = 1'b1;
  bit          srcGaps = 1'b0;
  bit          sinkStall = 1'b0;
  int          srcLeft = 0;
  int          accN = 0;
  int          outN = 0;
  int          curLen = 1;
  int          sampInPkt = 0;
  int          wordInPkt = 0;
  int          gapCnt = 0;
  int          stallCnt = 0;
  int          pktSeen = 0;
  int          r5Err = 0;
  int          r9Err = 0;
  bit          lastAccepted = 1'b0;
  bit          inPrefix = 1'b0;
  bit          prevStall = 1'b0;
  logic [31:0] prevData = '0;
  logic [95:0] accTime [0:255];
  logic [31:0] wData [0:255];
  logic        wSop [0:255];
  logic        wEop [0:255];

  sample_packet_framer dut_i (
    .clk(clk), .rstN(rstN),
    .inValid(inValid), .inReady(inReady), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outData(outData),
    .outSop(outSop), .outEop(outEop),
    .timeSec(timeSec), .timeFrac(timeFrac),
    .streamId(streamId), .pktLen(pktLen),
    .startEn(startEn), .startSec(startSec), .startFrac(startFrac)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // free-running time bus
  always @(posedge clk) begin
    if (timeRun) begin
      timeFrac <= timeFrac + 64'd1;
      if (&timeFrac) timeSec <= timeSec + 32'd1;
    end
  end

  // observe both streams away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      if (inPrefix && inReady) r5Err++;
      lastAccepted = inValid && inReady;
      if (lastAccepted) begin
        accTime[accN] = {timeSec, timeFrac};
        if (sampInPkt == 0) inPrefix = 1'b1;
        sampInPkt++;
        if (sampInPkt == curLen) sampInPkt = 0;
        accN++;
        srcLeft--;
      end
      if (prevStall && outValid && outData != prevData) r9Err++;
      prevStall = outValid && !outReady;
      prevData  = outData;
      if (outValid && outReady) begin
        wData[outN] = outData;
        wSop[outN]  = outSop;
        wEop[outN]  = outEop;
        if (outSop) wordInPkt = 0;
        if (wordInPkt == 5 || outEop) inPrefix = 1'b0;
        wordInPkt++;
        outN++;
      end
    end
  end

  // drive the next input and output-ready values just after the edge
  always @(posedge clk) begin
    #1;
    if (!(inValid && !lastAccepted)) begin
      inValid = (srcLeft > 0) && (!srcGaps || (gapCnt % 3) != 1);
      inData  = DATA_BASE + 32'(accN);
    end
    gapCnt++;
    stallCnt++;
    outReady = !sinkStall || (stallCnt % 3) != 0;
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nFail++;
      $display("FAIL watchdog: act=%0d cycles exp<=150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic startTraffic(input int nSamples, input int lenEff);
    @(posedge clk); #2;
    accN = 0; outN = 0; sampInPkt = 0; wordInPkt = 0;
    curLen = lenEff;
    srcLeft = nSamples;
  endtask

  task automatic waitWords(input int nWords, input string req);
    int guard = 0;
    while (outN < nWords && guard < 5000) begin
      @(posedge clk);
      guard++;
    end
    check(outN >= nWords, req, "word count", 64'(outN), 64'(nWords));
    repeat (3) @(posedge clk);
  endtask

  // check one packet starting at output word wb and input sample sb
  task automatic checkPacket(input int wb, input int sb, input int n,
                             input logic [31:0] expSid, input string tag);
    logic [95:0] t;
    logic        late;
    logic [31:0] hdr;
    t    = accTime[sb];
    late = startEn && (t > {startSec, startFrac});
    hdr  = {4'h1, late, 7'b0, 4'(pktSeen % 16), 16'(n + 5)};
    check(wData[wb] == hdr, "R2", {tag, " header"}, 64'(wData[wb]), 64'(hdr));
    check(wData[wb][19:16] == 4'(pktSeen % 16), "R8", {tag, " count"},
          64'(wData[wb][19:16]), 64'(pktSeen % 16));
    check(wData[wb][27] == late, "R7", {tag, " late"}, 64'(wData[wb][27]), 64'(late));
    check(wData[wb+1] == expSid, "R3", {tag, " stream id"}, 64'(wData[wb+1]), 64'(expSid));
    check(wData[wb+2] == t[95:64], "R4", {tag, " seconds"}, 64'(wData[wb+2]), 64'(t[95:64]));
    check(wData[wb+3] == t[63:32], "R4", {tag, " frac hi"}, 64'(wData[wb+3]), 64'(t[63:32]));
    check(wData[wb+4] == t[31:0], "R4", {tag, " frac lo"}, 64'(wData[wb+4]), 64'(t[31:0]));
    for (int i = 0; i < n + 5; i++) begin
      check(wSop[wb+i] == (i == 0), "R3", {tag, " sop"}, 64'(wSop[wb+i]), 64'(i == 0));
      check(wEop[wb+i] == (i == n + 4), "R6", {tag, " eop"}, 64'(wEop[wb+i]), 64'(i == n + 4));
    end
    for (int i = 0; i < n; i++) begin
      check(wData[wb+5+i] == DATA_BASE + 32'(sb + i), "R3", {tag, " payload"},
            64'(wData[wb+5+i]), 64'(DATA_BASE + 32'(sb + i)));
    end
    pktSeen++;
  endtask

  task automatic testReset();
    @(negedge clk);
    check(outValid == 1'b0, "R1", "outValid after reset", 64'(outValid), 64'd0);
    check(inReady == 1'b1, "R1", "inReady after reset", 64'(inReady), 64'd1);
    check(outSop == 1'b0 && outEop == 1'b0, "R1", "markers after reset",
          64'({outSop, outEop}), 64'd0);
  endtask

  task automatic testBasic();
    pktLen = 16'd4;
    startTraffic(4, 4);
    waitWords(9, "R6");
    checkPacket(0, 0, 4, streamId, "basic");
  endtask

  task automatic testShortLengths();
    pktLen = 16'd1;
    startTraffic(1, 1);
    waitWords(6, "R6");
    checkPacket(0, 0, 1, streamId, "len1");
    pktLen = 16'd0;
    startTraffic(1, 1);
    waitWords(6, "R6");
    checkPacket(0, 0, 1, streamId, "len0");
  endtask

  task automatic testBackpressure();
    pktLen = 16'd7;
    srcGaps = 1'b1; sinkStall = 1'b1; r9Err = 0;
    startTraffic(14, 7);
    waitWords(24, "R9");
    checkPacket(0, 0, 7, streamId, "stall p0");
    checkPacket(12, 7, 7, streamId, "stall p1");
    check(r9Err == 0, "R9", "data held while stalled", 64'(r9Err), 64'd0);
    srcGaps = 1'b0; sinkStall = 1'b0;
  endtask

  task automatic lateRun(input bit en, input int below, input string tag);
    logic [63:0] f;
    @(posedge clk); #2;
    f = timeFrac;
    startEn = en;
    startSec = timeSec;
    startFrac = f - 64'(below);
    pktLen = 16'd2;
    startTraffic(2, 2);
    waitWords(7, "R7");
    checkPacket(0, 0, 2, streamId, tag);
  endtask

  task automatic testLate();
    timeRun = 1'b0;
    lateRun(1'b1, 0, "late equal");
    check(wData[0][27] == 1'b0, "R7", "equal time not late", 64'(wData[0][27]), 64'd0);
    lateRun(1'b1, 1, "late below");
    check(wData[0][27] == 1'b1, "R7", "later sample flagged", 64'(wData[0][27]), 64'd1);
    lateRun(1'b0, 1, "late disabled");
    check(wData[0][27] == 1'b0, "R7", "disabled not late", 64'(wData[0][27]), 64'd0);
    timeRun = 1'b1;
    startEn = 1'b0;
  endtask

  task automatic testLatch();
    logic [31:0] sidA;
    sidA = 32'h00C0_FFEE;
    streamId = sidA;
    pktLen = 16'd3;
    startTraffic(3, 3);
    fork
      begin
        wait (accN == 1);
        @(posedge clk); #2;
        streamId = 32'h0BAD_0BAD;
        pktLen = 16'd9;
      end
    join_none
    waitWords(8, "R10");
    check(wData[1] == sidA, "R10", "stream id held", 64'(wData[1]), 64'(sidA));
    check(wData[0][15:0] == 16'd8, "R10", "length held", 64'(wData[0][15:0]), 64'd8);
    checkPacket(0, 0, 3, sidA, "latch");
    streamId = 32'h5151_0001;
  endtask

  task automatic testWrap();
    pktLen = 16'd1;
    startTraffic(17, 1);
    waitWords(102, "R8");
    for (int p = 0; p < 17; p++) checkPacket(p * 6, p, 1, streamId, "wrap");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    testReset();
    testBasic();
    testShortLengths();
    testBackpressure();
    testLate();
    testLatch();
    testWrap();
    check(r5Err == 0, "R5", "input closed during prefix", 64'(r5Err), 64'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule